// File: doc/BRIEF.md
# Byte Arithmetic Unit with Status Flags

This is a purely combinational 8-bit arithmetic core for an accumulator-style processor. Each cycle it takes the accumulator byte, a second operand byte, the current carry and auxiliary-carry flags and a 3-bit operation code. It returns the new accumulator byte, the new carry, auxiliary-carry, overflow and parity flag values, and a write-enable for each flag. The surrounding datapath commits the result and the enabled flags.

The unit supports plain add, add with carry, subtract with borrow, increment, decrement and a decimal adjust that corrects the binary sum of two packed BCD bytes. Subtraction always takes the incoming carry as a borrow, so a plain subtract requires the carry to be cleared first. Increment and decrement wrap around and do not touch the arithmetic flags.

Top module: `byte_alu`

## Requirements
- R1: With op_i = 3'd0 (add), res_o = acc_i + src_i modulo 256. cy_o is the carry out of bit 7, ac_o is the carry from bit 3 into bit 4, and cy_we_o, ac_we_o and ov_we_o are all 1.
- R2: With op_i = 3'd1 (add with carry), res_o = acc_i + src_i + cy_i modulo 256. cy_o and ac_o include the incoming carry, and all three arithmetic flag enables are 1.
- R3: With op_i = 3'd2 (subtract with borrow), res_o = acc_i - src_i - cy_i modulo 256. cy_o = 1 exactly when that difference is negative. ac_o = 1 exactly when the low nibble needs a borrow, meaning acc_i[3:0] < src_i[3:0] + cy_i. All three arithmetic flag enables are 1.
- R4: For ops 0, 1 and 2, ov_o = 1 exactly when the signed (two's complement) result falls outside -128..127.
- R5: For every op, par_o = 1 when res_o holds an odd number of ones and 0 when the count is even, and par_we_o = 1.
- R6: op_i = 3'd3 (increment) gives acc_i + 1 and op_i = 3'd4 (decrement) gives acc_i - 1, both wrapping modulo 256. For both, cy_we_o, ac_we_o and ov_we_o are 0.
- R7: op_i = 3'd5 (decimal adjust) first adds 0x06 when acc_i[3:0] > 9 or ac_i = 1. It then adds 0x60 when the corrected high nibble is > 9, when cy_i = 1, or when the first step carried out. cy_we_o = 1 and cy_o = cy_i OR any carry out, so the carry is never cleared. ac_we_o and ov_we_o are 0.
- R8: op_i = 3'd6 and 3'd7 are no-operations: res_o = acc_i, and cy_we_o, ac_we_o and ov_we_o are 0.
- R9: Plain add (op 0) ignores cy_i: the same operands give the same result and flags with cy_i = 0 and with cy_i = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_i | input | 8 | Accumulator operand |
| src_i | input | 8 | Second operand |
| cy_i | input | 1 | Current carry flag |
| ac_i | input | 1 | Current auxiliary carry flag |
| op_i | input | 3 | Operation code |
| res_o | output | 8 | Result byte |
| cy_o | output | 1 | New carry flag |
| ac_o | output | 1 | New auxiliary carry flag |
| ov_o | output | 1 | New overflow flag |
| par_o | output | 1 | New parity flag |
| cy_we_o | output | 1 | Carry write enable |
| ac_we_o | output | 1 | Auxiliary carry write enable |
| ov_we_o | output | 1 | Overflow write enable |
| par_we_o | output | 1 | Parity write enable |

## Verification
The add path is driven with sums that wrap to zero through both nibbles, with a sum that crosses the sign boundary without a carry out, and with a sweep of operand pairs. Together these separate the carry, auxiliary-carry and overflow conditions from one another. The subtract is driven with and without an incoming borrow, with a result that goes negative, and with a result that underflows in the signed sense, so that borrow and overflow are told apart. Decimal adjust is driven with low-only, high-cascaded, auxiliary-triggered and carry-held cases. Increment and decrement are driven at their wrap points.

// File: rtl/byte_alu.sv
module byte_alu (
  input  logic [7:0] acc_i,
  input  logic [7:0] src_i,
  input  logic       cy_i,
  input  logic       ac_i,
  input  logic [2:0] op_i,
  output logic [7:0] res_o,
  output logic       cy_o,
  output logic       ac_o,
  output logic       ov_o,
  output logic       par_o,
  output logic       cy_we_o,
  output logic       ac_we_o,
  output logic       ov_we_o,
  output logic       par_we_o
);
  localparam logic [2:0] OP_ADD  = 3'd0;
  localparam logic [2:0] OP_ADDC = 3'd1;
  localparam logic [2:0] OP_SUBB = 3'd2;
  localparam logic [2:0] OP_INC  = 3'd3;
  localparam logic [2:0] OP_DEC  = 3'd4;
  localparam logic [2:0] OP_DA   = 3'd5;

  logic       is_sub, is_arith, cin;
  logic [7:0] opb;
  logic [4:0] lo_sum;
  logic [7:0] low7_sum;
  logic [8:0] full_sum;

  assign is_sub   = (op_i == OP_SUBB);
  assign is_arith = (op_i == OP_ADD) || (op_i == OP_ADDC) || is_sub;
  assign opb      = is_sub ? ~src_i : src_i;
  assign cin      = (op_i == OP_ADDC) ? cy_i : (is_sub ? ~cy_i : 1'b0);

  assign lo_sum   = {1'b0, acc_i[3:0]} + {1'b0, opb[3:0]} + {4'd0, cin};
  assign low7_sum = {1'b0, acc_i[6:0]} + {1'b0, opb[6:0]} + {7'd0, cin};
  assign full_sum = {1'b0, acc_i} + {1'b0, opb} + {8'd0, cin};

  logic       lo_fix, hi_fix;
  logic [8:0] da_step1, da_step2;

  assign lo_fix   = (acc_i[3:0] > 4'd9) || ac_i;
  assign da_step1 = {1'b0, acc_i} + (lo_fix ? 9'h006 : 9'h000);
  assign hi_fix   = (da_step1[7:4] > 4'd9) || cy_i || da_step1[8];
  assign da_step2 = {1'b0, da_step1[7:0]} + (hi_fix ? 9'h060 : 9'h000);

  always_comb begin
    res_o = acc_i;
    cy_o  = cy_i;
    ac_o  = ac_i;
    ov_o  = 1'b0;
    unique case (op_i)
      OP_ADD, OP_ADDC, OP_SUBB: begin
        res_o = full_sum[7:0];
        cy_o  = full_sum[8] ^ is_sub;
        ac_o  = lo_sum[4] ^ is_sub;
        ov_o  = full_sum[8] ^ low7_sum[7];
      end
      OP_INC:  res_o = acc_i + 8'd1;
      OP_DEC:  res_o = acc_i - 8'd1;
      OP_DA: begin
        res_o = da_step2[7:0];
        cy_o  = cy_i | da_step1[8] | da_step2[8];
      end
      default: res_o = acc_i;
    endcase
  end

  assign par_o    = ^res_o;
  assign cy_we_o  = is_arith || (op_i == OP_DA);
  assign ac_we_o  = is_arith;
  assign ov_we_o  = is_arith;
  assign par_we_o = 1'b1;

  logic [8:0] ref_add, ref_sub;
  int         sgn_ref;
  assign ref_add = {1'b0, acc_i} + {1'b0, src_i} + {8'd0, (op_i == OP_ADDC) & cy_i};
  assign ref_sub = {1'b0, acc_i} - {1'b0, src_i} - {8'd0, cy_i};
  assign sgn_ref = is_sub ? (int'($signed(acc_i)) - int'($signed(src_i)) - int'(cy_i))
                          : (int'($signed(acc_i)) + int'($signed(src_i)) + int'((op_i == OP_ADDC) & cy_i));

  always_comb begin
    if (!$isunknown({acc_i, src_i, cy_i, ac_i, op_i})) begin
      if (op_i == OP_ADD || op_i == OP_ADDC)
        a_r1_add_sum: assert ({cy_o, res_o} == ref_add);
      if (is_sub)
        a_r3_sub_borrow: assert ({cy_o, res_o} == ref_sub);
      if (is_arith)
        a_r4_signed_range: assert (ov_o == (sgn_ref > 127 || sgn_ref < -128));
      a_r5_parity: assert (par_o == $countones(res_o) % 2);
      if (op_i == OP_INC || op_i == OP_DEC)
        a_r6_no_arith_flags: assert (!(cy_we_o || ac_we_o || ov_we_o));
      if (op_i == OP_DA && cy_i)
        a_r7_carry_sticky: assert (cy_o && cy_we_o);
    end
  end
endmodule

// File: tb/byte_alu_test.sv
module byte_alu_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [7:0] acc, src, res;
  logic       cyi, aci, cy, ac, ov, par, cy_we, ac_we, ov_we, par_we;
  logic [2:0] op;
  int nchk = 0, nfail = 0;
  bit done = 0;

  byte_alu uut (
    .acc_i(acc), .src_i(src), .cy_i(cyi), .ac_i(aci), .op_i(op),
    .res_o(res), .cy_o(cy), .ac_o(ac), .ov_o(ov), .par_o(par),
    .cy_we_o(cy_we), .ac_we_o(ac_we), .ov_we_o(ov_we), .par_we_o(par_we)
  );

  task automatic chk(input string req, input int got, input int exp);
    nchk++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [2:0] o, input logic [7:0] a, input logic [7:0] s,
                       input logic c, input logic x);
    @(negedge clk);
    op = o; acc = a; src = s; cyi = c; aci = x;
    #2;
  endtask

  task automatic check_flags(input string req, input int r, input int c, input int a,
                             input int v, input int p);
    chk({req, " res"}, res, r);
    chk({req, " cy"}, cy, c);
    chk({req, " ac"}, ac, a);
    chk({req, " ov"}, ov, v);
    chk({req, " par"}, par, p);
    chk({req, " we"}, {cy_we, ac_we, ov_we, par_we}, 4'b1111);
  endtask

  task automatic t_add;
    apply(3'd0, 8'hF5, 8'h0B, 1'b0, 1'b0);
    check_flags("R1 wrap", 8'h00, 1, 1, 0, 0);
    apply(3'd0, 8'h60, 8'h46, 1'b0, 1'b0);
    check_flags("R4 add ov", 8'hA6, 0, 0, 1, 0);
    for (int i = 0; i < 16; i++) begin
      int a, b, s, sa, sb;
      a = (i * 37 + 11) % 256; b = (i * 91 + 200) % 256;
      apply(3'd0, a[7:0], b[7:0], 1'b0, 1'b0);
      s = a + b;
      sa = (a > 127) ? a - 256 : a; sb = (b > 127) ? b - 256 : b;
      chk("R1 sweep res", res, s % 256);
      chk("R1 sweep cy", cy, s / 256);
      chk("R1 sweep ac", ac, ((a % 16) + (b % 16)) / 16);
      chk("R4 sweep ov", ov, int'((sa + sb) > 127 || (sa + sb) < -128));
    end
  endtask

  task automatic t_add_ignores_carry;
    apply(3'd0, 8'h10, 8'h20, 1'b1, 1'b0);
    check_flags("R9 cy ignored", 8'h30, 0, 0, 0, 0);
  endtask

  task automatic t_addc;
    apply(3'd1, 8'h3C, 8'h3B, 1'b1, 1'b0);
    check_flags("R2 addc", 8'h78, 0, 1, 0, 0);
    apply(3'd1, 8'hFF, 8'h00, 1'b1, 1'b0);
    check_flags("R2 addc carry", 8'h00, 1, 1, 0, 0);
  endtask

  task automatic t_subb;
    apply(3'd2, 8'h3F, 8'h23, 1'b0, 1'b0);
    check_flags("R3 plain", 8'h1C, 0, 0, 0, 1);
    apply(3'd2, 8'h62, 8'h96, 1'b0, 1'b0);
    check_flags("R3 negative", 8'hCC, 1, 1, 1, 0);
    apply(3'd2, 8'h27, 8'h12, 1'b1, 1'b0);
    check_flags("R3 borrow in", 8'h14, 0, 0, 0, 0);
    apply(3'd2, 8'h80, 8'h01, 1'b0, 1'b0);
    check_flags("R4 sub ov", 8'h7F, 0, 1, 1, 1);
  endtask

  task automatic t_incdec;
    apply(3'd3, 8'hFF, 8'h55, 1'b1, 1'b1);
    chk("R6 inc wrap", res, 8'h00);
    chk("R6 inc we", {cy_we, ac_we, ov_we}, 3'b000);
    chk("R5 inc par", {par, par_we}, 2'b01);
    apply(3'd4, 8'h00, 8'h55, 1'b0, 1'b0);
    chk("R6 dec wrap", res, 8'hFF);
    chk("R6 dec we", {cy_we, ac_we, ov_we}, 3'b000);
    apply(3'd3, 8'h7F, 8'h00, 1'b0, 1'b0);
    chk("R6 inc sign", res, 8'h80);
    chk("R5 inc par odd", par, 1);
  endtask

  task automatic t_da;
    apply(3'd5, 8'h6C, 8'h00, 1'b0, 1'b0);
    chk("R7 low fix", res, 8'h72);
    chk("R7 low fix cy", {cy, cy_we, ac_we, ov_we}, 4'b0100);
    apply(3'd5, 8'h9A, 8'h00, 1'b0, 1'b0);
    chk("R7 cascade", res, 8'h00);
    chk("R7 cascade cy", cy, 1);
    apply(3'd5, 8'h61, 8'h00, 1'b0, 1'b1);
    chk("R7 ac fix", res, 8'h67);
    apply(3'd5, 8'h12, 8'h00, 1'b1, 1'b0);
    chk("R7 cy held", {res, cy}, {8'h72, 1'b1});
  endtask

  task automatic t_nop;
    apply(3'd6, 8'h5A, 8'hFF, 1'b1, 1'b1);
    chk("R8 op6", {res, cy_we, ac_we, ov_we}, {8'h5A, 3'b000});
    apply(3'd7, 8'hC3, 8'h01, 1'b0, 1'b0);
    chk("R8 op7", {res, cy_we, ac_we, ov_we}, {8'hC3, 3'b000});
  endtask

  initial begin
    op = 3'd6; acc = 8'h00; src = 8'h00; cyi = 1'b0; aci = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    chk("R8 idle", {res, cy_we, ac_we, ov_we, par_we}, {8'h00, 4'b0001});
    t_add();
    t_add_ignores_carry();
    t_addc();
    t_subb();
    t_incdec();
    t_da();
    t_nop();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule